// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block runs one I2C message on a status-coded master engine with no software in the loop. The host loads a message descriptor and pulses a start strobe. The descriptor holds the target address (7 or 10 bits), a read flag, a direction-inversion flag, a ten-bit flag, a skip-start flag and a byte count. From then on the sequencer reacts to each engine interrupt. It takes the engine's status code, picks the next action, and issues one or two register writes on the engine's write port. Bytes for transmission come from the head of a byte FIFO, and received bytes are pushed into a second FIFO.

A message ends with a single-cycle done pulse and a two-bit result code. The sequencer can also run the engine's bring-up sequence. A programmable cycle timeout moves a stalled message into an abort state. In that state the next interrupt closes the bus with STOP.

The engine must drop its interrupt on the clock edge that takes a control-register write, and it must present `status_i` and `rx_data_i` while the interrupt is high.

Top module: `i2c_msg_seq`

## Requirements
- R1: A pulse on `init_i` while idle produces five back-to-back writes on consecutive cycles, starting one cycle after the pulse, in this order: select 5 with data 0, select 2 with `div_i`, select 3 with 0, select 4 with 0, then select 1 with 0x50. The select codes are: 0 data, 1 control, 2 clock divider, 3 slave address, 4 extended slave address, 5 soft reset. `busy_o` is low again once the last write is on the port.
- R2: The control bits are ACK enable (bit 2), STOP (bit 4), START (bit 5), engine enable (bit 6) and interrupt enable (bit 7), with base value 0xC4. When a start is accepted without the skip-start flag, the next cycle carries a control write of 0xE4.
- R3: The first address byte is {addr[6:0], dir} for 7-bit targets and 0xF0 | addr[9:8]<<1 | dir for 10-bit targets, where dir = read flag XOR inversion flag. Status 0x08 or 0x10 writes this byte to the data register, followed on the next cycle by a control write of the current control value.
- R4: On status 0x18 (ten-bit flag clear), 0xD0 or 0x28 with bytes left, the FIFO head is written to the data register with `tx_pop_o` high, followed by a control write. With no bytes left, a STOP control write is issued and the message ends with result 0.
- R5: On status 0x40 (ten-bit flag clear) or 0xE0 with bytes left, only a control write is issued and nothing is pushed. With no bytes left, a STOP write is issued. Status 0x50 pushes `rx_data_i` and decrements the count.
- R6: When exactly one read byte remains, the control value written has the ACK bit cleared. Status 0x58 pushes the byte, issues STOP and ends the message.
- R7: Result codes are 0 none, 1 no device, 2 I/O error and 3 timeout. Statuses 0x20, 0x30 and 0x48 issue STOP and give result 1. Any status outside the handled set issues STOP and gives result 2.
- R8: Every control write that carries STOP has interrupt enable clear.
- R9: With the skip-start flag, a read begins with a control write only (ACK cleared if the count is 1). A write begins by sending its first FIFO byte with the count decremented.
- R10: If no interrupt arrives for `tmo_i` cycles while a message is active, the sequencer enters an abort state. The next interrupt issues a STOP write and ends the message with result 3. A second silent timeout ends it with result 3 and no write.
- R11: An interrupt while idle causes one STOP control write and no done pulse.
- R12: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle. After reset, `busy_o`, `done_o` and `wr_en_o` are low.
- R13: With the ten-bit flag set, status 0x18 or 0x40 writes addr[7:0] as the second address byte, followed by a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Run the engine bring-up sequence |
| div_i | input | 8 | Clock divider value for bring-up |
| tmo_i | input | TMO_W | Timeout limit in cycles |
| start_i | input | 1 | Accept the descriptor and begin |
| desc_addr_i | input | 10 | Target address |
| desc_rd_i | input | 1 | Read message |
| desc_rev_i | input | 1 | Invert the direction bit |
| desc_ten_i | input | 1 | 10-bit addressing |
| desc_nostart_i | input | 1 | Skip START and address phases |
| desc_len_i | input | CNT_W | Byte count |
| irq_i | input | 1 | Engine interrupt flag |
| status_i | input | 8 | Engine status code |
| rx_data_i | input | 8 | Engine received byte |
| tx_data_i | input | 8 | Transmit FIFO head |
| tx_pop_o | output | 1 | Pop transmit FIFO |
| rx_push_o | output | 1 | Push receive FIFO |
| rx_data_o | output | 8 | Byte to receive FIFO |
| wr_en_o | output | 1 | Engine register write strobe |
| wr_sel_o | output | 3 | Engine register select |
| wr_data_o | output | 8 | Engine register write data |
| busy_o | output | 1 | Message or bring-up in progress |
| done_o | output | 1 | Message finished |
| err_o | output | 2 | Result code, valid with done |

## Verification
Several rules are checked by the assertions on every cycle. A data write is always followed by a control write, a FIFO pop only ever rides on a data write, and a receive push only on a control write. No STOP write leaves interrupt enable set, and a final received byte always gets STOP with ACK clear. The done pulse lasts one cycle, falls with busy, and carries a STOP write unless it is a silent timeout. The bench scenarios are the only place that shows the exact bytes and their order. That covers address framing for both widths, the count-driven choice between data and STOP, the ACK drop on the last read, the error code for each status class, and the timing of the abort path.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RS_DATA = 3'd0, RS_CTRL = 3'd1, RS_DIV = 3'd2,
    RS_SADR = 3'd3, RS_XSADR = 3'd4, RS_SRST = 3'd5
  } reg_sel_e;

  localparam int CB_ACK   = 2;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [BYTE_W-1:0] M_ACK   = BYTE_W'(1) << CB_ACK;
  localparam logic [BYTE_W-1:0] M_STOP  = BYTE_W'(1) << CB_STOP;
  localparam logic [BYTE_W-1:0] M_START = BYTE_W'(1) << CB_START;
  localparam logic [BYTE_W-1:0] M_EN    = BYTE_W'(1) << CB_EN;
  localparam logic [BYTE_W-1:0] M_IEN   = BYTE_W'(1) << CB_IEN;
  localparam logic [BYTE_W-1:0] CTL_BASE = M_ACK | M_EN | M_IEN;
  localparam logic [BYTE_W-1:0] CTL_INIT = M_EN | M_STOP;

  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_WA_ACK  = 8'h18;
  localparam logic [7:0] SC_WA_NAK  = 8'h20;
  localparam logic [7:0] SC_WD_ACK  = 8'h28;
  localparam logic [7:0] SC_WD_NAK  = 8'h30;
  localparam logic [7:0] SC_RA_ACK  = 8'h40;
  localparam logic [7:0] SC_RA_NAK  = 8'h48;
  localparam logic [7:0] SC_RD_ACK  = 8'h50;
  localparam logic [7:0] SC_RD_NAK  = 8'h58;
  localparam logic [7:0] SC_WA2_ACK = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK = 8'hE0;

  typedef enum logic [1:0] {ERR_NONE, ERR_NODEV, ERR_IO, ERR_TMO} err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_WSTART, ST_WADR1, ST_WADR2, ST_WACK, ST_WDATA, ST_ABORT
  } seq_st_e;

  typedef enum logic [2:0] {
    AC_CONT, AC_START, AC_ADR1, AC_ADR2, AC_SEND, AC_RECV, AC_RECV_STOP, AC_STOP
  } act_e;

  typedef enum logic [1:0] {EX_IDLE, EX_DATA, EX_CTRL} ex_e;
endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
(
  input  logic [9:0]        addr_i,
  input  logic              rd_i,
  input  logic              rev_i,
  input  logic              ten_i,
  output logic [BYTE_W-1:0] byte1_o,
  output logic [BYTE_W-1:0] byte2_o
);
  logic dir;
  assign dir     = rd_i ^ rev_i;
  assign byte1_o = ten_i ? {5'b11110, addr_i[9:8], dir} : {addr_i[6:0], dir};
  assign byte2_o = addr_i[7:0];
endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [7:0]       status_i,
  input  logic             ten_i,
  input  logic [CNT_W-1:0] left_i,
  output act_e             act_o,
  output seq_st_e          st_o,
  output err_e             err_o,
  output logic             dec_o,
  output logic             clr_ack_o
);
  logic zero, one, two;
  assign zero = (left_i == '0);
  assign one  = (left_i == CNT_W'(1));
  assign two  = (left_i == CNT_W'(2));

  always_comb begin
    act_o = AC_STOP; st_o = ST_IDLE; err_o = ERR_NONE;
    dec_o = 1'b0; clr_ack_o = 1'b0;
    case (status_i)
      SC_START, SC_RSTART: begin act_o = AC_ADR1; st_o = ST_WADR1; end
      SC_WA_ACK, SC_WA2_ACK, SC_WD_ACK: begin
        if (status_i == SC_WA_ACK && ten_i) begin
          act_o = AC_ADR2; st_o = ST_WADR2;
        end else if (!zero) begin
          act_o = AC_SEND; st_o = ST_WACK; dec_o = 1'b1;
        end
      end
      SC_RA_ACK, SC_RA2_ACK: begin
        if (status_i == SC_RA_ACK && ten_i) begin
          act_o = AC_ADR2; st_o = ST_WADR2;
        end else if (!zero) begin
          act_o = AC_CONT; st_o = ST_WDATA; clr_ack_o = one;
        end
      end
      SC_RD_ACK: begin
        act_o = AC_RECV; st_o = ST_WDATA; dec_o = 1'b1; clr_ack_o = two;
      end
      SC_RD_NAK: act_o = AC_RECV_STOP;
      SC_WA_NAK, SC_WD_NAK, SC_RA_NAK: err_o = ERR_NODEV;
      default: err_o = ERR_IO;
    endcase
  end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;
  assign expired_o = run_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !run_i)  cnt_q <= '0;
    else if (!expired_o)         cnt_q <= cnt_q + TMO_W'(1);
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [BYTE_W-1:0] div_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              start_i,
  input  logic [9:0]        desc_addr_i,
  input  logic              desc_rd_i,
  input  logic              desc_rev_i,
  input  logic              desc_ten_i,
  input  logic              desc_nostart_i,
  input  logic [CNT_W-1:0]  desc_len_i,
  input  logic              irq_i,
  input  logic [7:0]        status_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              wr_en_o,
  output logic [2:0]        wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  seq_st_e           state_q;
  ex_e               ex_q;
  logic [2:0]        step_q;
  logic [BYTE_W-1:0] ctl_q, ctl_wr_q, adr1_q, adr2_q, rx_dat_q, wr_dat_q;
  logic [CNT_W-1:0]  left_q;
  logic              ten_q, fin_q, wr_en_q, tx_pop_q, rx_push_q, done_q;
  reg_sel_e          wr_sel_q;
  err_e              err_q;

  logic [BYTE_W-1:0] a1, a2;
  act_e              d_act;
  seq_st_e           d_st;
  err_e              d_err;
  logic              d_dec, d_clr, tmo;

  i2c_seq_addr u_addr (
    .addr_i(desc_addr_i), .rd_i(desc_rd_i), .rev_i(desc_rev_i),
    .ten_i(desc_ten_i), .byte1_o(a1), .byte2_o(a2)
  );

  i2c_seq_decode #(.CNT_W(CNT_W)) u_dec (
    .status_i(status_i), .ten_i(ten_q), .left_i(left_q),
    .act_o(d_act), .st_o(d_st), .err_o(d_err), .dec_o(d_dec), .clr_ack_o(d_clr)
  );

  // next-action selection
  logic    fire, is_start, abort_now, quit_now, dec, clr, fin;
  act_e    act;
  seq_st_e nst;
  err_e    nerr;

  always_comb begin
    fire = 1'b0; is_start = 1'b0; abort_now = 1'b0; quit_now = 1'b0;
    act = AC_STOP; nst = ST_IDLE; nerr = err_q; dec = 1'b0; clr = 1'b0; fin = 1'b0;
    if (ex_q == EX_IDLE) begin
      case (state_q)
        ST_IDLE: if (!init_i) begin
          if (start_i) begin
            fire = 1'b1; is_start = 1'b1; nerr = ERR_NONE;
            if (!desc_nostart_i) begin
              act = AC_START; nst = ST_WSTART;
            end else if (desc_rd_i) begin
              act = AC_CONT; nst = ST_WDATA; clr = (desc_len_i == CNT_W'(1));
            end else begin
              act = AC_SEND; nst = ST_WACK; dec = 1'b1;
            end
          end else if (irq_i) begin
            fire = 1'b1;  // stray event: close bus
          end
        end
        ST_INIT: ;
        ST_ABORT: begin
          if (irq_i) begin fire = 1'b1; fin = 1'b1; nerr = ERR_TMO; end
          else if (tmo) quit_now = 1'b1;
        end
        default: begin
          if (irq_i) begin
            fire = 1'b1; act = d_act; nst = d_st; nerr = d_err;
            dec = d_dec; clr = d_clr;
            fin = (d_act == AC_STOP) || (d_act == AC_RECV_STOP);
          end else if (tmo) abort_now = 1'b1;
        end
      endcase
    end
  end

  logic [CNT_W-1:0]  left_src, left_nx;
  logic [BYTE_W-1:0] ctl_src, ctl_n, ctl_keep, ctl_go;
  logic              stop_act;

  assign left_src = is_start ? desc_len_i : left_q;
  assign left_nx  = left_src - CNT_W'(dec);
  assign ctl_src  = is_start ? CTL_BASE : ctl_q;
  assign ctl_n    = clr ? (ctl_src & ~M_ACK) : ctl_src;
  assign stop_act = (act == AC_STOP) || (act == AC_RECV_STOP);
  assign ctl_keep = stop_act ? (ctl_n & ~M_IEN) : ctl_n;
  assign ctl_go   = stop_act ? (ctl_keep | M_STOP)
                  : (act == AC_START) ? (ctl_n | M_START) : ctl_n;

  i2c_seq_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(fire || abort_now),
    .run_i((state_q != ST_IDLE) && (state_q != ST_INIT)),
    .limit_i(tmo_i), .expired_o(tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  ex_q <= EX_IDLE;  step_q <= '0;
      ctl_q <= M_EN;       ctl_wr_q <= '0;   adr1_q <= '0;  adr2_q <= '0;
      left_q <= '0;        ten_q <= 1'b0;    fin_q <= 1'b0; err_q <= ERR_NONE;
      wr_en_q <= 1'b0;     wr_sel_q <= RS_DATA; wr_dat_q <= '0;
      tx_pop_q <= 1'b0;    rx_push_q <= 1'b0; rx_dat_q <= '0; done_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0; tx_pop_q <= 1'b0; rx_push_q <= 1'b0; done_q <= 1'b0;
      case (ex_q)
        EX_DATA: begin
          wr_en_q <= 1'b1; wr_sel_q <= RS_CTRL; wr_dat_q <= ctl_wr_q;
          done_q <= fin_q; ex_q <= EX_CTRL;
        end
        EX_CTRL: ex_q <= EX_IDLE;
        default: begin
          if (state_q == ST_INIT) begin
            wr_en_q <= 1'b1;
            step_q  <= step_q + 3'd1;
            case (step_q)
              3'd1: begin wr_sel_q <= RS_DIV;   wr_dat_q <= div_i; end
              3'd2: begin wr_sel_q <= RS_SADR;  wr_dat_q <= '0;    end
              3'd3: begin wr_sel_q <= RS_XSADR; wr_dat_q <= '0;    end
              default: begin
                wr_sel_q <= RS_CTRL; wr_dat_q <= CTL_INIT;
                ctl_q <= CTL_INIT & ~M_STOP; state_q <= ST_IDLE; ex_q <= EX_CTRL;
              end
            endcase
          end else if (state_q == ST_IDLE && init_i) begin
            wr_en_q <= 1'b1; wr_sel_q <= RS_SRST; wr_dat_q <= '0;
            step_q <= 3'd1; state_q <= ST_INIT;
          end else if (fire) begin
            state_q <= nst; err_q <= nerr; left_q <= left_nx;
            ctl_q <= ctl_keep; ctl_wr_q <= ctl_go; fin_q <= fin;
            if (is_start) begin ten_q <= desc_ten_i; adr1_q <= a1; adr2_q <= a2; end
            wr_en_q <= 1'b1;
            case (act)
              AC_ADR1: begin wr_sel_q <= RS_DATA; wr_dat_q <= adr1_q; ex_q <= EX_DATA; end
              AC_ADR2: begin wr_sel_q <= RS_DATA; wr_dat_q <= adr2_q; ex_q <= EX_DATA; end
              AC_SEND: begin
                wr_sel_q <= RS_DATA; wr_dat_q <= tx_data_i; tx_pop_q <= 1'b1; ex_q <= EX_DATA;
              end
              default: begin
                wr_sel_q <= RS_CTRL; wr_dat_q <= ctl_go; done_q <= fin; ex_q <= EX_CTRL;
                if (act == AC_RECV || act == AC_RECV_STOP) begin
                  rx_push_q <= 1'b1; rx_dat_q <= rx_data_i;
                end
              end
            endcase
          end else if (abort_now) begin
            state_q <= ST_ABORT; err_q <= ERR_TMO;
          end else if (quit_now) begin
            state_q <= ST_IDLE; done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign tx_pop_o  = tx_pop_q;
  assign rx_push_o = rx_push_q;
  assign rx_data_o = rx_dat_q;
  assign wr_en_o   = wr_en_q;
  assign wr_sel_o  = wr_sel_q;
  assign wr_data_o = wr_dat_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  AST_CTRL_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_sel_o == RS_DATA |=> wr_en_o && wr_sel_o == RS_CTRL); // R4
  AST_POP_ON_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> wr_en_o && wr_sel_o == RS_DATA); // R4
  AST_PUSH_ON_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> wr_en_o && wr_sel_o == RS_CTRL); // R5
  AST_LAST_BYTE_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o && wr_data_o[CB_STOP] |-> !wr_data_o[CB_ACK]); // R6
  AST_STOP_NO_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_sel_o == RS_CTRL && wr_data_o[CB_STOP] |-> !wr_data_o[CB_IEN]); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R12
  AST_DONE_WITH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o != ERR_TMO |-> wr_en_o && wr_sel_o == RS_CTRL && wr_data_o[CB_STOP]); // R7
endmodule

// File: tb/test_i2c_msg_seq.sv
`timescale 1ns/1ps
module test_i2c_msg_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0, start = 1'b0;
  logic [7:0] div = 8'h00;
  logic [15:0] tmo = 16'd1000;
  logic [9:0] d_addr = '0;
  logic       d_rd = 0, d_rev = 0, d_ten = 0, d_nos = 0;
  logic [7:0] d_len = '0;
  logic       irq = 1'b0;
  logic [7:0] status = '0, rx_in = '0, tx_head;
  logic       tx_pop, rx_push, wr_en, busy, done;
  logic [7:0] rx_out, wr_data;
  logic [2:0] wr_sel;
  logic [1:0] err;

  always #2 clk = ~clk;  // 250 MHz

  i2c_msg_seq i_i2c_msg_seq (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .div_i(div), .tmo_i(tmo),
    .start_i(start), .desc_addr_i(d_addr), .desc_rd_i(d_rd), .desc_rev_i(d_rev),
    .desc_ten_i(d_ten), .desc_nostart_i(d_nos), .desc_len_i(d_len),
    .irq_i(irq), .status_i(status), .rx_data_i(rx_in), .tx_data_i(tx_head),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_out),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0;

  task automatic chk(input int req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL R%0d got 0x%0h exp 0x%0h", req, got, exp);
    end
  endtask

  // transmit FIFO model
  logic [7:0] tx_mem [0:63];
  int tx_wr = 0, tx_rd = 0;
  assign tx_head = tx_mem[tx_rd % 64];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;
  task automatic tx_put(input logic [7:0] b);
    tx_mem[tx_wr % 64] = b; tx_wr++;
  endtask

  // engine model: raises irq on request, drops it on a control write
  int raise = 0, seen = 0;
  always @(posedge clk) begin
    if (wr_en && wr_sel == 3'd1) irq <= 1'b0;
    else if (raise != seen) begin irq <= 1'b1; seen <= raise; end
  end

  // reference expectations
  int wq[$], wreq[$], rq[$], dq[$];
  task automatic ew(input int req, input int sel, input int dat);
    wq.push_back(sel * 256 + dat); wreq.push_back(req);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (wq.size() == 0) chk(0, wr_sel * 256 + wr_data, -1);
      else chk(wreq.pop_front(), wr_sel * 256 + wr_data, wq.pop_front());
    end
    if (rx_push) begin
      if (rq.size() == 0) chk(5, rx_out, -1);
      else chk(5, rx_out, rq.pop_front());  // R5 R6
    end
    if (done) begin
      if (dq.size() == 0) chk(12, err, -1);
      else chk(7, err, dq.pop_front());  // R7 R12
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic [9:0] a, input logic rd, rev, ten, nos, input logic [7:0] len);
    @(negedge clk);
    d_addr = a; d_rd = rd; d_rev = rev; d_ten = ten; d_nos = nos; d_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle(3);
  endtask

  task automatic ev(input logic [7:0] s, input logic [7:0] r);
    @(negedge clk);
    status = s; rx_in = r; raise++;
    @(negedge clk);
    for (int i = 0; i < 40 && irq; i++) @(negedge clk);
    idle(2);
  endtask

  task automatic drained(input int req);
    chk(req, wq.size() + rq.size() + dq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(12, {busy, done, wr_en}, 0);  // R12 reset state

    // R1 bring-up
    div = 8'h2B;
    ew(1, 5, 0); ew(1, 2, 8'h2B); ew(1, 3, 0); ew(1, 4, 0); ew(1, 1, 8'h50);
    @(negedge clk); init = 1'b1; @(negedge clk); init = 1'b0;
    idle(7);
    chk(1, busy, 0);
    drained(1);

    // R2 R3 R4: 7-bit write of two bytes
    tx_put(8'hA1); tx_put(8'hA2);
    ew(2, 1, 8'hE4);
    go(10'h050, 0, 0, 0, 0, 8'd2);
    chk(12, busy, 1);
    ew(3, 0, 8'hA0); ew(3, 1, 8'hC4); ev(8'h08, 0);
    ew(4, 0, 8'hA1); ew(4, 1, 8'hC4); ev(8'h18, 0);
    ew(4, 0, 8'hA2); ew(4, 1, 8'hC4); ev(8'h28, 0);
    ew(4, 1, 8'h54); dq.push_back(0); ev(8'h28, 0);
    chk(12, busy, 0);
    drained(4);

    // R13 R5 R6: 10-bit read of two bytes
    ew(2, 1, 8'hE4); go(10'h2A5, 1, 0, 1, 0, 8'd2);
    ew(3, 0, 8'hF5); ew(3, 1, 8'hC4); ev(8'h08, 0);
    ew(13, 0, 8'hA5); ew(13, 1, 8'hC4); ev(8'h40, 0);
    ew(5, 1, 8'hC4); ev(8'hE0, 0);
    rq.push_back(8'h3C); ew(6, 1, 8'hC0); ev(8'h50, 8'h3C);
    rq.push_back(8'h7E); ew(6, 1, 8'h50); dq.push_back(0); ev(8'h58, 8'h7E);
    drained(6);

    // R3 R6: 7-bit single-byte read with inverted direction
    ew(2, 1, 8'hE4); go(10'h013, 1, 1, 0, 0, 8'd1);
    ew(3, 0, 8'h26); ew(3, 1, 8'hC4); ev(8'h10, 0);
    ew(6, 1, 8'hC0); ev(8'h40, 0);
    rq.push_back(8'h99); ew(6, 1, 8'h50); dq.push_back(0); ev(8'h58, 8'h99);
    drained(6);

    // R7 no device
    ew(2, 1, 8'hE4); go(10'h07F, 0, 0, 0, 0, 8'd1);
    ew(3, 0, 8'hFE); ew(3, 1, 8'hC4); ev(8'h08, 0);
    ew(7, 1, 8'h54); dq.push_back(1); ev(8'h20, 0);
    drained(7);

    // R7 unexpected status
    ew(2, 1, 8'hE4); go(10'h001, 0, 0, 0, 0, 8'd1);
    ew(3, 0, 8'h02); ew(3, 1, 8'hC4); ev(8'h08, 0);
    ew(7, 1, 8'h54); dq.push_back(2); ev(8'hF8, 0);
    drained(7);

    // R13 R4: 10-bit write with zero bytes
    ew(2, 1, 8'hE4); go(10'h3FF, 0, 0, 1, 0, 8'd0);
    ew(3, 0, 8'hF6); ew(3, 1, 8'hC4); ev(8'h08, 0);
    ew(13, 0, 8'hFF); ew(13, 1, 8'hC4); ev(8'h18, 0);
    ew(4, 1, 8'h54); dq.push_back(0); ev(8'hD0, 0);
    drained(13);

    // R9 skip-start read, one byte
    ew(9, 1, 8'hC0); go(10'h000, 1, 0, 0, 1, 8'd1);
    rq.push_back(8'h11); ew(9, 1, 8'h50); dq.push_back(0); ev(8'h58, 8'h11);
    drained(9);

    // R9 skip-start write, one byte
    tx_put(8'hB7);
    ew(9, 0, 8'hB7); ew(9, 1, 8'hC4); go(10'h000, 0, 0, 0, 1, 8'd1);
    ew(9, 1, 8'h54); dq.push_back(0); ev(8'h28, 0);
    drained(9);

    // R11 stray event while idle
    ew(11, 1, 8'h54); ev(8'h08, 0);
    chk(11, busy, 0);
    drained(11);

    // R10 timeout then event
    tmo = 16'd20;
    ew(2, 1, 8'hE4); go(10'h022, 0, 0, 0, 0, 8'd1);
    idle(27);
    chk(10, {busy, done}, 2'b10);
    ew(10, 1, 8'h54); dq.push_back(3); ev(8'h08, 0);
    chk(10, busy, 0);
    drained(10);

    // R10 double timeout, no bus write
    ew(2, 1, 8'hE4); dq.push_back(3); go(10'h022, 0, 0, 0, 0, 8'd1);
    idle(70);
    chk(10, busy, 0);
    drained(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule